// File: doc/BRIEF.md
# Secondary-PWM bridge gate timing generator

This block times the gates of an isolated full-bridge converter in which the primary bridge runs free and only the synchronous secondary rectifier is pulse-width modulated. The primary side has two diagonal pairs, A and B. They alternate at one fixed frequency, each on for roughly half the period, with a programmable dead interval after each pair. Neither the duty command nor the gate timing shifts their phase.

Two secondary gates carry the regulation. S2 rises on the same cycle as pair A and S1 rises with pair B. Each stays high for half a period plus a fraction of half a period set by the duty command. A zero command gives a half-period pulse and zero output; the largest command stretches the pulse toward a full period. The stretch is clamped so that every secondary pulse ends a programmable guard interval before the pair it overlaps starts its dead interval. The primary switches therefore only break magnetizing current. Period, dead time, guard and duty are captured once per period, at its first count. A run of 100 kHz from a 250 MHz clock needs a period count of 2500.

Top module: `sec_pwm_gate_gen`

## Requirements
- R1: While reset is active, or on the cycle after `en` is sampled low, all four gate outputs are low.
- R2: With period P, dead count D and h = floor(P/2), pair A is high at counts 0 to h-D-1 of each period and pair B at counts h to P-D-1. The two pairs are never high on the same cycle, and the duty command never alters either.
- R3: The cycle after `en` is first sampled high is count 0 of a period, so pair A (when h > D) and S2 are high on that cycle.
- R4: S2 rises on the same cycle as pair A, and S1 rises on the same cycle as pair B.
- R5: Each secondary pulse lasts h + floor(h * duty / 2^DUTY_W) cycles when unclamped, so a duty of 0 gives exactly h cycles.
- R6: The stretch is limited to P - h - D - G, with guard G, so S2 is low for at least G cycles before B's dead interval and S1 for at least G cycles before A's dead interval. A guard input of 0 acts as 1.
- R7: Period, dead, guard and duty are captured only at count 0 of a period. A change later in a period leaves the pulse in progress unchanged. When a period change would move the guard point, an S1 pulse carried into the new period is cut at the new guard point.
- R8: A period input below 2 acts as 2. With D = 0, A and B then alternate on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low forces all gates low |
| period_cnt | input | CNT_W | Switching period in clock cycles |
| dead_cnt | input | CNT_W | Dead interval after each primary pair, in cycles |
| guard_cnt | input | CNT_W | Minimum gap between a secondary turn-off and the overlapped pair's dead interval |
| duty_cmd | input | DUTY_W | Stretch fraction of half a period, duty / 2^DUTY_W |
| pa_gate | output | 1 | Primary pair A gate |
| pb_gate | output | 1 | Primary pair B gate |
| s1_gate | output | 1 | Secondary switch S1 gate (starts with pair B) |
| s2_gate | output | 1 | Secondary switch S2 gate (starts with pair A) |

## Verification
The bench targets five corners. The first is a full-scale duty command that would run a secondary pulse into the primary turn-off; an unclamped design would leave S2 or S1 high when the pair starts its dead interval. The second is an odd period, where S1 carries a tail across the period boundary; a design that forgot the tail would cut S1 short at the period edge. The third is a duty change in the middle of a pulse, where a design that sampled continuously would stretch the running pulse. The fourth is a period too small to hold, where a design that did not force it to 2 would lock up or leave both pairs dark. The bench also starts with a large period and switches to a short one, where the carried S1 tail must be cut at the new guard point rather than overlap the new pair A turn-off.

// File: rtl/sec_pwm_gate_pkg.sv
package sec_pwm_gate_pkg;

  // One bit per gate, registered together at the block edge.
  typedef struct packed {
    logic pa;
    logic pb;
    logic s1;
    logic s2;
  } gate_set_t;

  localparam gate_set_t GATES_OFF = '{pa: 1'b0, pb: 1'b0, s1: 1'b0, s2: 1'b0};

endpackage

// File: rtl/gsg_shape_calc.sv
// Turns the raw per-period settings into the count boundaries of one period.
module gsg_shape_calc #(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 8
) (
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  dead_i,
  input  logic [CNT_W-1:0]  guard_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  half_o,
  output logic [CNT_W-1:0]  ext_o,
  output logic [CNT_W-1:0]  a_end_o,
  output logic [CNT_W-1:0]  b_end_o,
  output logic [CNT_W-1:0]  s2_end_o,
  output logic [CNT_W-1:0]  lim_o
);
  localparam int XW = CNT_W + 1;
  localparam int PW = CNT_W + DUTY_W;

  logic [CNT_W-1:0] per_e, half, g_e, raw, emax, ext;
  logic [XW-1:0]    rest_x, dg_x, half_x;
  logic [PW-1:0]    prod;

  always_comb begin
    per_e  = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;   // R8
    half   = per_e >> 1;
    g_e    = (guard_i == '0) ? CNT_W'(1) : guard_i;           // R6 guard floor
    rest_x = {1'b0, per_e - half};
    half_x = {1'b0, half};
    dg_x   = {1'b0, dead_i} + {1'b0, g_e};
    emax   = (rest_x > dg_x) ? CNT_W'(rest_x - dg_x) : '0;
    prod   = PW'(half) * PW'(duty_i);
    raw    = CNT_W'(prod >> DUTY_W);
    ext    = (raw < emax) ? raw : emax;
  end

  assign per_o    = per_e;
  assign half_o   = half;
  assign ext_o    = ext;
  assign a_end_o  = (half > dead_i) ? half - dead_i : '0;
  assign b_end_o  = (per_e > dead_i) ? per_e - dead_i : '0;
  assign s2_end_o = half + ext;
  assign lim_o    = (half_x > dg_x) ? CNT_W'(half_x - dg_x) : '0;

endmodule

// File: rtl/gsg_phase_ctr.sv
// Free-running period counter; flags the first count of each period.
module gsg_phase_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_q,
  output logic             start_o,
  output logic             run_nxt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  always_comb begin
    start = en && (!run_q || (cnt_q == per_q - CNT_W'(1)));
    run_d = en;
    if (!en)        cnt_d = '0;
    else if (start) cnt_d = '0;
    else            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign start_o   = start;
  assign run_nxt_o = run_d;
  assign cnt_nxt_o = cnt_d;

endmodule

// File: rtl/gsg_gate_decode.sv
// Maps a count and the captured boundaries onto the four gates.
module gsg_gate_decode
  import sec_pwm_gate_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] a_end_i,
  input  logic [CNT_W-1:0] b_end_i,
  input  logic [CNT_W-1:0] s2_end_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W-1:0] tail_i,
  output gate_set_t        gates_o
);
  always_comb begin
    gates_o = GATES_OFF;
    if (run_i) begin
      gates_o.pa = cnt_i < a_end_i;
      gates_o.pb = (cnt_i >= half_i) && (cnt_i < b_end_i);
      gates_o.s2 = cnt_i < s2_end_i;
      gates_o.s1 = (cnt_i >= half_i) || ((cnt_i < tail_i) && (cnt_i < lim_i));
    end
  end

endmodule

// File: rtl/sec_pwm_gate_gen.sv
module sec_pwm_gate_gen
  import sec_pwm_gate_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  period_cnt,
  input  logic [CNT_W-1:0]  dead_cnt,
  input  logic [CNT_W-1:0]  guard_cnt,
  input  logic [DUTY_W-1:0] duty_cmd,
  output logic              pa_gate,
  output logic              pb_gate,
  output logic              s1_gate,
  output logic              s2_gate
);
  localparam int XW = CNT_W + 1;

  // Reset: asserts at once, releases on the second clock edge.
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  // Settings turned into boundaries, ready for capture at period start.
  logic [CNT_W-1:0] c_per, c_half, c_ext, c_a_end, c_b_end, c_s2_end, c_lim;

  gsg_shape_calc #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_calc (
    .period_i (period_cnt),
    .dead_i   (dead_cnt),
    .guard_i  (guard_cnt),
    .duty_i   (duty_cmd),
    .per_o    (c_per),
    .half_o   (c_half),
    .ext_o    (c_ext),
    .a_end_o  (c_a_end),
    .b_end_o  (c_b_end),
    .s2_end_o (c_s2_end),
    .lim_o    (c_lim)
  );

  // Captured boundaries of the running period.
  logic [CNT_W-1:0] per_q, half_q, ext_q, a_end_q, b_end_q, s2_end_q, lim_q, tail_q;
  logic [CNT_W-1:0] per_d, half_d, ext_d, a_end_d, b_end_d, s2_end_d, lim_d, tail_d;

  logic             start, run_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  gsg_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rs_q),
    .en        (en),
    .per_q     (per_q),
    .start_o   (start),
    .run_nxt_o (run_nxt),
    .cnt_nxt_o (cnt_nxt)
  );

  // S1 portion that spills into the next period: 2h + ext - P of the old period.
  logic [XW-1:0]    spill_x;
  logic [CNT_W-1:0] spill;
  always_comb begin
    spill_x = {half_q, 1'b0} + XW'(ext_q);
    spill   = (spill_x > XW'(per_q)) ? CNT_W'(spill_x - XW'(per_q)) : '0;
  end

  // Next-state selection of the captured boundaries (R7).
  always_comb begin
    per_d    = per_q;
    half_d   = half_q;
    ext_d    = ext_q;
    a_end_d  = a_end_q;
    b_end_d  = b_end_q;
    s2_end_d = s2_end_q;
    lim_d    = lim_q;
    tail_d   = tail_q;
    if (!run_nxt) begin
      per_d    = '0;
      half_d   = '0;
      ext_d    = '0;
      a_end_d  = '0;
      b_end_d  = '0;
      s2_end_d = '0;
      lim_d    = '0;
      tail_d   = '0;
    end else if (start) begin
      per_d    = c_per;
      half_d   = c_half;
      ext_d    = c_ext;
      a_end_d  = c_a_end;
      b_end_d  = c_b_end;
      s2_end_d = c_s2_end;
      lim_d    = c_lim;
      tail_d   = (per_q == '0) ? '0 : spill;   // no spill into the first period
    end
  end

  gate_set_t gates_d, gates_q;

  gsg_gate_decode #(.CNT_W(CNT_W)) u_dec (
    .run_i    (run_nxt),
    .cnt_i    (cnt_nxt),
    .half_i   (half_d),
    .a_end_i  (a_end_d),
    .b_end_i  (b_end_d),
    .s2_end_i (s2_end_d),
    .lim_i    (lim_d),
    .tail_i   (tail_d),
    .gates_o  (gates_d)
  );

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      per_q    <= '0;
      half_q   <= '0;
      ext_q    <= '0;
      a_end_q  <= '0;
      b_end_q  <= '0;
      s2_end_q <= '0;
      lim_q    <= '0;
      tail_q   <= '0;
      gates_q  <= GATES_OFF;
    end else begin
      per_q    <= per_d;
      half_q   <= half_d;
      ext_q    <= ext_d;
      a_end_q  <= a_end_d;
      b_end_q  <= b_end_d;
      s2_end_q <= s2_end_d;
      lim_q    <= lim_d;
      tail_q   <= tail_d;
      gates_q  <= gates_d;
    end
  end

  assign pa_gate = gates_q.pa;
  assign pb_gate = gates_q.pb;
  assign s1_gate = gates_q.s1;
  assign s2_gate = gates_q.s2;

endmodule

// File: rtl/sec_pwm_gate_chk.sv
module sec_pwm_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pa_gate,
  input logic pb_gate,
  input logic s1_gate,
  input logic s2_gate
);
  p_pairs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_gate && pb_gate));

  p_idle_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pa_gate && !pb_gate && !s1_gate && !s2_gate));

  p_s2_with_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_gate) |-> $rose(s2_gate));

  p_s1_with_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_gate) |-> $rose(s1_gate));

  p_s1_off_before_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pa_gate) && $past(en)) |-> !$past(s1_gate));

  p_s2_off_before_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pb_gate) && $past(en)) |-> !$past(s2_gate));

endmodule

bind sec_pwm_gate_gen sec_pwm_gate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .pa_gate (pa_gate),
  .pb_gate (pb_gate),
  .s1_gate (s1_gate),
  .s2_gate (s2_gate)
);

// File: tb/sec_pwm_gate_gen_tb_top.sv
`timescale 1ns/1ps
module sec_pwm_gate_gen_tb_top;
  localparam int CW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, en;
  logic [CW-1:0] period_cnt, dead_cnt, guard_cnt;
  logic [DW-1:0] duty_cmd;
  logic pa_gate, pb_gate, s1_gate, s2_gate;

  always #2 clk = ~clk;   // 250 MHz

  sec_pwm_gate_gen #(.CNT_W(CW), .DUTY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_cnt(period_cnt), .dead_cnt(dead_cnt), .guard_cnt(guard_cnt),
    .duty_cmd(duty_cmd),
    .pa_gate(pa_gate), .pb_gate(pb_gate), .s1_gate(s1_gate), .s2_gate(s2_gate)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";

  // ---- behavioural reference: period position and per-period settings ----
  int m_run, m_cnt, m_per, m_h, m_ext, m_d, m_g, m_tail, m_s1, m_s2;
  bit e_pa, e_pb, e_s1, e_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_cnt = 0; m_per = 0; m_h = 0;
      m_ext = 0; m_d = 0; m_g = 1; m_tail = 0;
    end else begin
      if (!(m_s2 == 1 && en)) begin
        m_run = 0; m_cnt = 0; m_per = 0; m_h = 0; m_ext = 0; m_d = 0; m_g = 1; m_tail = 0;
      end else if (m_run == 0 || m_cnt == m_per - 1) begin
        int carry, lim_max, raw;
        carry = (m_run == 1) ? (2 * m_h + m_ext - m_per) : 0;
        if (carry < 0) carry = 0;
        m_per = (int'(period_cnt) < 2) ? 2 : int'(period_cnt);
        m_h   = m_per / 2;
        m_d   = int'(dead_cnt);
        m_g   = (guard_cnt == 0) ? 1 : int'(guard_cnt);
        lim_max = m_per - m_h - m_d - m_g;
        if (lim_max < 0) lim_max = 0;
        raw   = (m_h * int'(duty_cmd)) / (1 << DW);
        m_ext = (raw < lim_max) ? raw : lim_max;
        m_tail = carry;
        m_cnt = 0;
        m_run = 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always_comb begin
    int guard_pt;
    guard_pt = m_h - m_d - m_g;
    if (guard_pt < 0) guard_pt = 0;
    e_pa = (m_run == 1) && (m_cnt < m_h - m_d);
    e_pb = (m_run == 1) && (m_cnt >= m_h) && (m_cnt < m_per - m_d);
    e_s2 = (m_run == 1) && (m_cnt < m_h + m_ext);
    e_s1 = (m_run == 1) && ((m_cnt >= m_h) || (m_cnt < m_tail && m_cnt < guard_pt));
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    n_cmp++;
    if ({pa_gate, pb_gate, s1_gate, s2_gate} !== {e_pa, e_pb, e_s1, e_s2}) begin
      n_bad++;
      $display("FAIL %s (R2 pairs / R5 secondaries) t=%0t actual pa,pb,s1,s2=%b%b%b%b expected=%b%b%b%b",
               tag, $time, pa_gate, pb_gate, s1_gate, s2_gate, e_pa, e_pb, e_s1, e_s2);
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // Width of the next pulse on S1 or S2; optional duty change right after its rise.
  task automatic meas(input bit use_s1, input int chg, output int w, output bit aligned);
    bit prev, cur, p_prev, p_cur;
    w = 0; aligned = 0; prev = 1; p_prev = 1; cur = 0; p_cur = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cur   = use_s1 ? s1_gate : s2_gate;
      p_cur = use_s1 ? pb_gate : pa_gate;
      if (cur && !prev) break;
      prev = cur; p_prev = p_cur;
    end
    aligned = p_cur && !p_prev;
    if (chg >= 0) duty_cmd = DW'(chg);
    while (cur && w < 400) begin
      w++;
      @(negedge clk);
      cur = use_s1 ? s1_gate : s2_gate;
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w; bit al; bit a0, b0, a1, b1;
    rst_n = 0; en = 0; period_cnt = 20; dead_cnt = 2; guard_cnt = 1; duty_cmd = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset dark", {pa_gate, pb_gate, s1_gate, s2_gate}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle dark", {pa_gate, pb_gate, s1_gate, s2_gate}, 0);

    tag = "R3"; en = 1;
    @(negedge clk);
    chk("R3 first cycle pair A", pa_gate, 1);
    chk("R3 first cycle S2", s2_gate, 1);

    tag = "R5";
    meas(0, -1, w, al); chk("R5 S2 width duty 0", w, 10);
    chk("R4 S2 rises with pair A", al, 1);
    meas(1, -1, w, al); chk("R5 S1 width duty 0", w, 10);
    chk("R4 S1 rises with pair B", al, 1);
    duty_cmd = 128; repeat (25) @(negedge clk);
    meas(0, -1, w, al); chk("R5 S2 width duty half", w, 15);

    tag = "R6";
    duty_cmd = 255; repeat (25) @(negedge clk);
    meas(0, -1, w, al); chk("R6 S2 clamp guard 1", w, 17);
    guard_cnt = 3; repeat (25) @(negedge clk);
    meas(0, -1, w, al); chk("R6 S2 clamp guard 3", w, 15);
    guard_cnt = 0; repeat (25) @(negedge clk);
    meas(0, -1, w, al); chk("R6 guard 0 acts as 1", w, 17);
    guard_cnt = 1; period_cnt = 21; repeat (25) @(negedge clk);
    meas(1, -1, w, al); chk("R6 S1 odd period with tail", w, 18);

    tag = "R7";
    period_cnt = 20; duty_cmd = 0; repeat (45) @(negedge clk);
    meas(0, 255, w, al); chk("R7 mid-pulse duty change ignored", w, 10);
    meas(0, -1, w, al); chk("R7 new duty at next period", w, 17);
    period_cnt = 40; repeat (90) @(negedge clk);
    period_cnt = 12; repeat (60) @(negedge clk);   // carried S1 tail cut, reference checks
    period_cnt = 40; repeat (25) @(negedge clk);
    period_cnt = 6;  repeat (80) @(negedge clk);

    tag = "R8";
    period_cnt = 0; dead_cnt = 0; duty_cmd = 0; repeat (50) @(negedge clk);
    a0 = pa_gate; b0 = pb_gate;
    @(negedge clk);
    a1 = pa_gate; b1 = pb_gate;
    chk("R8 pairs alternate each cycle", {a0, b0, a1, b1} == 4'b1001 || {a0, b0, a1, b1} == 4'b0110, 1);

    tag = "R2";
    period_cnt = 30; dead_cnt = 3; duty_cmd = 200; repeat (120) @(negedge clk);
    duty_cmd = 17; repeat (70) @(negedge clk);

    tag = "R1";
    en = 0;
    @(negedge clk);
    chk("R1 disable darkens gates", {pa_gate, pb_gate, s1_gate, s2_gate}, 0);
    repeat (5) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule